// File: doc/BRIEF.md
# In-Order Base IPC Estimator

This block predicts how many instructions per cycle a 4-wide in-order core would sustain when no cache misses occur, using only a histogram of producer-to-consumer distances gathered while the workload ran on a different core. A scheduler supplies three histogram bins: the number of instructions whose nearest consumer is 1, 2 or 3 instructions later. It also supplies the instruction count for the interval. From these the block forms per-distance probabilities and the probability that an issue group of 1, 2, 3 or 4 instructions forms. It then computes the weighted expected IPC and its reciprocal, the base CPI.

The work is sequenced. A pulse on `start` while idle latches the inputs. One restoring divider and one fixed-point multiplier are reused across the whole run. A one-cycle `done` pulse marks new results on `ipc_est` and `cpi_est`, and those results hold until the next run completes. All fractions use 12 fractional bits, so 1.0 is the code 4096. Latencies of more than one cycle and structural conflicts are not modelled.

Top module: `base_ipc_est`

## Requirements
- R1: After reset `busy` and `done` are 0, and `ipc_est` and `cpi_est` are 0.
- R2: `start` is sampled only while idle, at a clock edge E0. `busy` is 1 from E0 until the edge E0+54. `done` is 1 for exactly the cycle that follows edge E0+53.
- R3: Each probability Pk (k = 1, 2, 3) is floor(countk·4096/total) when countk < total. It is 4096 when countk >= total and total > 0. It is 0 when total = 0.
- R4: The cumulative sums C2 = P1+P2 and C3 = P1+P2+P3 are limited to 4096 before use, so every one-minus term (4096−C) is at least 0.
- R5: Every product of two fractions is truncated: (a·b)>>12. With A = ((4096−P1)·(4096−C2))>>12, the group probabilities are G2 = ((4096−P1)·C2)>>12, G3 = (A·C3)>>12 and G4 = (A·(4096−C3))>>12.
- R6: `ipc_est` equals P1 + 2·G2 + 3·G3 + 4·G4, with 12 fractional bits in a 15-bit field.
- R7: An IPC value below 4096 (1.0) is replaced by 4096.
- R8: `cpi_est` equals floor(2^24 / `ipc_est`), with 12 fractional bits in a 13-bit field. It therefore lies between 1024 and 4096.
- R9: A `start` pulse while busy is ignored. Changes to the count inputs after E0 do not affect the run in progress.
- R10: `ipc_est` and `cpi_est` change only at the edge that raises `done`, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an estimate (taken only while idle) |
| dist1_cnt | input | CW | Count of distance-1 dependencies |
| dist2_cnt | input | CW | Count of distance-2 dependencies |
| dist3_cnt | input | CW | Count of distance-3 dependencies |
| instr_cnt | input | CW | Instructions in the interval |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: results updated |
| ipc_est | output | FRAC+3 | Estimated base IPC, 12 fractional bits |
| cpi_est | output | FRAC+1 | Estimated base CPI, 12 fractional bits |

## Verification
A wrong divider step or a mis-stored probability appears as a wrong `ipc_est` at the next `done`, 54 cycles after the start. A wrong sequencer count shifts `done` or `busy` by a cycle, and the per-clock comparison with the reference model catches that at once. A misrouted multiplier operand usually shows up in the capping or clamping corner cases. In those cases one group term dominates, so the error is large and visible in the first run that reaches it.

// File: rtl/ibe_pkg.sv
package ibe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV,
        ST_MUL,
        ST_SUM,
        ST_DONE
    } ibe_state_e;
endpackage

// File: rtl/ibe_div_step.sv
// One restoring-division iteration: shift the remainder, subtract if it fits.
module ibe_div_step #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] rem_i,
    input  logic [DW-1:0] den_i,
    output logic [DW-1:0] rem_o,
    output logic          bit_o
);
    always_comb begin
        bit_o = ({rem_i, 1'b0} >= {1'b0, den_i});
        rem_o = DW'(bit_o ? ({rem_i, 1'b0} - {1'b0, den_i}) : {rem_i, 1'b0});
    end
endmodule

// File: rtl/ibe_qmul.sv
// Shared fraction multiplier, truncating back to FRAC fractional bits.
module ibe_qmul #(
    parameter int PW   = 13,
    parameter int FRAC = 12
) (
    input  logic [PW-1:0] a_i,
    input  logic [PW-1:0] b_i,
    output logic [PW-1:0] p_o
);
    localparam int MW = 2 * PW;

    always_comb begin
        p_o = PW'((MW'(a_i) * MW'(b_i)) >> FRAC);
    end
endmodule

// File: rtl/ibe_ipc_sum.sv
// Weighted sum of issue-group probabilities with a 1.0 floor.
module ibe_ipc_sum #(
    parameter int PW   = 13,
    parameter int FRAC = 12,
    parameter int IW   = 15
) (
    input  logic [PW-1:0] g1_i,
    input  logic [PW-1:0] g2_i,
    input  logic [PW-1:0] g3_i,
    input  logic [PW-1:0] g4_i,
    output logic [IW-1:0] ipc_o
);
    localparam int SW = IW + 2;
    localparam logic [SW-1:0] FLOOR = SW'(1) << FRAC;

    logic [SW-1:0] sum;

    always_comb begin
        sum = SW'(g1_i) + (SW'(g2_i) << 1) + SW'(g3_i) + (SW'(g3_i) << 1) + (SW'(g4_i) << 2);
        ipc_o = (sum < FLOOR) ? IW'(FLOOR) : IW'(sum);
    end
endmodule

// File: rtl/base_ipc_est.sv
module base_ipc_est
    import ibe_pkg::*;
#(
    parameter int CW   = 16,
    parameter int FRAC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CW-1:0]   dist1_cnt,
    input  logic [CW-1:0]   dist2_cnt,
    input  logic [CW-1:0]   dist3_cnt,
    input  logic [CW-1:0]   instr_cnt,
    output logic            busy,
    output logic            done,
    output logic [FRAC+2:0] ipc_est,
    output logic [FRAC:0]   cpi_est
);
    localparam int PW = FRAC + 1;
    localparam int IW = FRAC + 3;
    localparam int DW = (CW > IW + 1) ? CW : IW + 1;
    localparam int SW = $clog2(FRAC);
    localparam logic [PW-1:0] UNIT = {1'b1, {FRAC{1'b0}}};

    typedef struct packed {
        ibe_state_e      state;
        logic [1:0]      sel;
        logic [SW-1:0]   step;
        logic [DW-1:0]   rem;
        logic [FRAC-2:0] quo;
        logic [CW-1:0]   c1;
        logic [CW-1:0]   c2;
        logic [CW-1:0]   c3;
        logic [CW-1:0]   tot;
        logic [PW-1:0]   p1;
        logic [PW-1:0]   p2;
        logic [PW-1:0]   p3;
        logic [PW-1:0]   m1;
        logic [PW-1:0]   g2;
        logic [PW-1:0]   g3;
        logic [PW-1:0]   g4;
        logic [1:0]      midx;
        logic [IW-1:0]   ipc;
        logic [IW-1:0]   ipc_out;
        logic [PW-1:0]   cpi_out;
    } regs_t;

    regs_t st_q, st_d;

    function automatic logic [DW-1:0] pick_num(input logic [1:0] s, input logic [CW-1:0] a,
                                               input logic [CW-1:0] b, input logic [CW-1:0] c);
        case (s)
            2'd0:    return DW'(a);
            2'd1:    return DW'(b);
            2'd2:    return DW'(c);
            default: return DW'(UNIT);
        endcase
    endfunction

    // cumulative probabilities, limited to 1.0
    logic [PW:0]   sum2;
    logic [PW+1:0] sum3;
    logic [PW-1:0] cum2, cum3, om1, om2, om3;

    always_comb begin
        sum2 = (PW+1)'(st_q.p1) + (PW+1)'(st_q.p2);
        sum3 = (PW+2)'(sum2) + (PW+2)'(st_q.p3);
        cum2 = (sum2 >= (PW+1)'(UNIT)) ? UNIT : PW'(sum2);
        cum3 = (sum3 >= (PW+2)'(UNIT)) ? UNIT : PW'(sum3);
        om1  = UNIT - st_q.p1;
        om2  = UNIT - cum2;
        om3  = UNIT - cum3;
    end

    // shared divider datapath
    logic [DW-1:0] div_num, div_den, step_rem;
    logic          step_bit;
    logic [PW-1:0] div_res;

    always_comb begin
        div_num = pick_num(st_q.sel, st_q.c1, st_q.c2, st_q.c3);
        div_den = (st_q.sel == 2'd3) ? DW'(st_q.ipc) : DW'(st_q.tot);
    end

    ibe_div_step #(.DW(DW)) u_step (
        .rem_i (st_q.rem),
        .den_i (div_den),
        .rem_o (step_rem),
        .bit_o (step_bit)
    );

    always_comb begin
        if (div_den == '0)
            div_res = '0;
        else if (div_num >= div_den)
            div_res = UNIT;
        else
            div_res = {1'b0, st_q.quo, step_bit};
    end

    // shared multiplier datapath
    logic [PW-1:0] mul_a, mul_b, mul_p;

    always_comb begin
        case (st_q.midx)
            2'd0:    begin mul_a = om1;     mul_b = om2;  end
            2'd1:    begin mul_a = om1;     mul_b = cum2; end
            2'd2:    begin mul_a = st_q.m1; mul_b = cum3; end
            default: begin mul_a = st_q.m1; mul_b = om3;  end
        endcase
    end

    ibe_qmul #(.PW(PW), .FRAC(FRAC)) u_mul (
        .a_i (mul_a),
        .b_i (mul_b),
        .p_o (mul_p)
    );

    logic [IW-1:0] ipc_sum;

    ibe_ipc_sum #(.PW(PW), .FRAC(FRAC), .IW(IW)) u_sum (
        .g1_i  (st_q.p1),
        .g2_i  (st_q.g2),
        .g3_i  (st_q.g3),
        .g4_i  (st_q.g4),
        .ipc_o (ipc_sum)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.c1    = dist1_cnt;
                    st_d.c2    = dist2_cnt;
                    st_d.c3    = dist3_cnt;
                    st_d.tot   = instr_cnt;
                    st_d.sel   = 2'd0;
                    st_d.step  = '0;
                    st_d.rem   = DW'(dist1_cnt);
                    st_d.quo   = '0;
                    st_d.state = ST_DIV;
                end
            end
            ST_DIV: begin
                st_d.rem  = step_rem;
                st_d.quo  = {st_q.quo[FRAC-3:0], step_bit};
                st_d.step = st_q.step + SW'(1);
                if (st_q.step == SW'(FRAC - 1)) begin
                    st_d.step = '0;
                    st_d.quo  = '0;
                    st_d.sel  = st_q.sel + 2'd1;
                    st_d.rem  = pick_num(st_q.sel + 2'd1, st_q.c1, st_q.c2, st_q.c3);
                    case (st_q.sel)
                        2'd0: st_d.p1 = div_res;
                        2'd1: st_d.p2 = div_res;
                        2'd2: begin
                            st_d.p3    = div_res;
                            st_d.midx  = 2'd0;
                            st_d.state = ST_MUL;
                        end
                        default: begin
                            st_d.cpi_out = div_res;
                            st_d.ipc_out = st_q.ipc;
                            st_d.state   = ST_DONE;
                        end
                    endcase
                end
            end
            ST_MUL: begin
                st_d.midx = st_q.midx + 2'd1;
                case (st_q.midx)
                    2'd0: st_d.m1 = mul_p;
                    2'd1: st_d.g2 = mul_p;
                    2'd2: st_d.g3 = mul_p;
                    default: begin
                        st_d.g4    = mul_p;
                        st_d.state = ST_SUM;
                    end
                endcase
            end
            ST_SUM: begin
                st_d.ipc   = ipc_sum;
                st_d.sel   = 2'd3;
                st_d.step  = '0;
                st_d.quo   = '0;
                st_d.rem   = DW'(UNIT);
                st_d.state = ST_DIV;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.state != ST_IDLE);
    assign done    = (st_q.state == ST_DONE);
    assign ipc_est = st_q.ipc_out;
    assign cpi_est = st_q.cpi_out;
endmodule

// File: rtl/ibe_checker.sv
module ibe_checker #(
    parameter int FRAC = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic [FRAC+2:0] ipc_est,
    input logic [FRAC:0]   cpi_est
);
    localparam int ONE = 1 << FRAC;

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r2_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r9_run_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r7_ipc_floor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ipc_est >= ONE && ipc_est <= 4 * ONE));
    a_r8_cpi_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cpi_est <= ONE && cpi_est >= ONE / 4));
    a_r10_ipc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ipc_est) |-> done);
    a_r10_cpi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpi_est) |-> done);
endmodule

bind base_ipc_est ibe_checker #(.FRAC(FRAC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .ipc_est (ipc_est),
    .cpi_est (cpi_est)
);

// File: tb/base_ipc_est_bench.sv
module base_ipc_est_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] d1 = '0, d2 = '0, d3 = '0, tot = '0;
    logic        busy, done;
    logic [14:0] ipc_est;
    logic [12:0] cpi_est;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit live = 1'b0;

    always #5 clk = ~clk;

    base_ipc_est u_base_ipc_est (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dist1_cnt (d1),
        .dist2_cnt (d2),
        .dist3_cnt (d3),
        .instr_cnt (tot),
        .busy      (busy),
        .done      (done),
        .ipc_est   (ipc_est),
        .cpi_est   (cpi_est)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference
    function automatic int prob(input int c, input int t);
        if (t == 0) return 0;
        if (c >= t) return 4096;
        return (c * 4096) / t;
    endfunction

    function automatic int ref_ipc(input int c1, input int c2, input int c3, input int t);
        int p1, p2, p3, k2, k3, o1, o2, o3, a, g2, g3, g4, r;
        p1 = prob(c1, t); p2 = prob(c2, t); p3 = prob(c3, t);
        k2 = (p1 + p2 > 4096) ? 4096 : p1 + p2;
        k3 = (p1 + p2 + p3 > 4096) ? 4096 : p1 + p2 + p3;
        o1 = 4096 - p1; o2 = 4096 - k2; o3 = 4096 - k3;
        a  = (o1 * o2) >> 12;
        g2 = (o1 * k2) >> 12;
        g3 = (a * k3) >> 12;
        g4 = (a * o3) >> 12;
        r  = p1 + 2 * g2 + 3 * g3 + 4 * g4;
        return (r < 4096) ? 4096 : r;
    endfunction

    int m_busy = 0, m_done = 0, m_cnt = 0, m_ipc = 0, m_cpi = 0, m_pend_ipc = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_ipc = 0; m_cpi = 0;
        end else if (m_busy == 0) begin
            if (start) begin
                m_busy = 1; m_cnt = 0;
                m_pend_ipc = ref_ipc(int'(d1), int'(d2), int'(d3), int'(tot));
            end
        end else begin
            m_cnt++;
            if (m_cnt == 53) begin
                m_done = 1;
                m_ipc = m_pend_ipc;
                m_cpi = 16777216 / m_pend_ipc;
            end else if (m_cnt == 54) begin
                m_done = 0; m_busy = 0;
            end
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (live) begin
            check(int'(busy) == m_busy, "R2 busy", int'(busy), m_busy);
            check(int'(done) == m_done, "R2 done", int'(done), m_done);
            check(int'(ipc_est) == m_ipc, "R6 R10 ipc_est", int'(ipc_est), m_ipc);
            check(int'(cpi_est) == m_cpi, "R8 R10 cpi_est", int'(cpi_est), m_cpi);
        end
    end

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic run(input int c1, input int c2, input int c3, input int t,
                       input int e_ipc, input int e_cpi, input string tag);
        @(negedge clk);
        d1 = 16'(c1); d2 = 16'(c2); d3 = 16'(c3); tot = 16'(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(done == 1'b1, {tag, " done seen"}, int'(done), 1);
        if (e_ipc >= 0) begin
            check(int'(ipc_est) == e_ipc, {tag, " ipc"}, int'(ipc_est), e_ipc);
            check(int'(cpi_est) == e_cpi, {tag, " cpi"}, int'(cpi_est), e_cpi);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(ipc_est == '0, "R1 ipc", int'(ipc_est), 0);
        check(cpi_est == '0, "R1 cpi", int'(cpi_est), 0);
        live = 1'b1;

        run(0, 0, 0, 0, 16384, 1024, "R3 zero total");
        run(150, 0, 0, 100, 4096, 4096, "R3 saturated P1");
        run(1, 0, 0, 3, 9855, 1702, "R5 R6 R8 mixed");
        run(0, 100, 0, 100, 8192, 2048, "R5 all distance two");
        run(1, 2, 3, 4, 7936, 2114, "R4 capped C3");
        run(4095, 0, 0, 4096, 4096, 4096, "R7 floor at one");

        // R9: second start and new counts during a run are ignored
        @(negedge clk);
        d1 = 16'd1; d2 = 16'd0; d3 = 16'd0; tot = 16'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        d1 = 16'd0; tot = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(int'(ipc_est) == 9855, "R9 ipc", int'(ipc_est), 9855);
        check(int'(cpi_est) == 1702, "R9 cpi", int'(cpi_est), 1702);
        @(negedge clk);
        check(busy == 1'b0, "R9 no second run", int'(busy), 0);

        for (int n = 0; n < 24; n++) begin
            int t;
            t = (n % 8 == 7) ? 0 : int'($urandom_range(1, 5000));
            run(int'($urandom_range(0, t / 2)), int'($urandom_range(0, t / 2)),
                int'($urandom_range(0, t)), t, -1, -1, "R6 random");
        end

        live = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule